// File: doc/BRIEF.md
# Clock Manager Safe-Mode Controller

This block decides, for two clock domains, whether the clock-generation logic runs from the settings that software programmed or from the raw oscillator. The debug domain holds every debug clock. The normal domain holds every other clock. Each domain has a sticky safe flag. A cold reset or a safe-mode request from the reset controller sets both flags. A warm reset sets each flag only when that domain's warm-response enable is 1. Only a software write-1-to-clear can drop a flag.

Software reaches the block through a small register port. The port holds the warm-response enables, the two safe flags, the gate enables of the software-managed clocks, and one generator configuration word for each domain. While a domain is safe, the block keeps the stored values of that domain untouched. At the outputs it forces the configuration word to a fixed safe value and drives every gate enable to 0. It also raises a bypass select for the domain, which routes the oscillator straight to that domain's clocks.

Top module: `clkmgr_safe_ctrl`

## Requirements
- R1: For each domain, the bypass select (`norm_bypass_o`, `dbg_bypass_o`) equals that domain's safe flag. While the flag is 1, the domain's configuration output equals `SAFE_CFG` (default 0).
- R2: A cold reset returns every register to its default. This means a low `rst_n` at a clock edge, or a high `cold_rst` at a clock edge. The defaults are: both safe flags 1, both warm enables 1, all gate enables 0, both configuration words 0.
- R3: `safe_req` high at a clock edge sets both safe flags. It leaves the enables, the gates and the configuration words unchanged.
- R4: The status register is at address 1: bit 0 is the normal flag, bit 1 is the debug flag. Writing 1 to a bit clears that flag and writing 0 leaves it alone. No other write and no hardware event clears a flag.
- R5: Writes to the gate and configuration registers while a domain is safe are stored and can be read back. That domain's outputs stay forced.
- R6: On `warm_rst`, the normal flag is set if control bit 0 is 1, and the debug flag is set if control bit 1 is 1. A domain whose bit is 0 keeps its flag.
- R7: The control register is at address 0, bits [1:0], and both bits reset to 1 on a cold reset. A warm reset or a safe request leaves them unchanged.
- R8: Each gate-enable output is 0 while its domain is safe. Once the flag is clear, it follows the stored bit. At address 2, bits [3:0] are the normal gates and bits [5:4] are the debug gates.
- R9: If a set event and a write-1-to-clear hit the same flag at the same edge, the flag ends up 1. A set event is a cold reset, `safe_req`, or an enabled `warm_rst`.
- R10: Address 3 holds the normal configuration word and address 4 holds the debug one, in bits [7:0]. `rdata` is combinational from the current register state while `rd_en` is high. It is 0 for addresses 5 to 7 and 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, with the same effect as a cold reset |
| cold_rst | input | 1 | Cold-reset event from the reset controller |
| warm_rst | input | 1 | Warm-reset event from the reset controller |
| safe_req | input | 1 | Safe-mode request from the reset controller |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| norm_cfg_o | output | 8 | Effective normal-domain generator configuration |
| dbg_cfg_o | output | 8 | Effective debug-domain generator configuration |
| norm_gate_o | output | 4 | Effective normal-domain gate enables |
| dbg_gate_o | output | 2 | Effective debug-domain gate enables |
| norm_bypass_o | output | 1 | Route the oscillator to the normal domain |
| dbg_bypass_o | output | 1 | Route the oscillator to the debug domain |

## Verification
Read data has no latency: the bench drives a read on the falling edge and compares `rdata` one nanosecond later against the model state from before the next rising edge. Every write, reset and request lands at the rising edge that samples it. The forced outputs and the bypass selects are combinational from those registers, so the bench advances its model at that edge and compares all output ports at the following falling edge. Directed steps cover the corner cases: a clear in the same cycle as a request, and warm resets with each enable pattern. A seeded random phase then mixes all events, with unmapped addresses included.

// File: rtl/clkmgr_safe_pkg.sv
// Package: register addresses and domain indices shared by the safe-mode
// controller and its submodules. Assumes a byte-free word address space.
package clkmgr_safe_pkg;
    localparam int N_DOM    = 2;
    localparam int DOM_NORM = 0;
    localparam int DOM_DBG  = 1;
    localparam int ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_GATE = 3'd2;
    localparam logic [ADDR_W-1:0] A_NCFG = 3'd3;
    localparam logic [ADDR_W-1:0] A_DCFG = 3'd4;
endpackage

// File: rtl/clkmgr_safe_regs.sv
// Stored settings: warm-response enables, gate enables and the two generator
// configuration words. Assumes cold_rst is a single-cycle synchronous event;
// warm reset and safe requests never touch these registers.
module clkmgr_safe_regs
    import clkmgr_safe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NG     = 4,
    parameter int DG     = 2,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              safe_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_DOM-1:0]  warm_en,
    output logic [NG+DG-1:0]  gate_q,
    output logic [CFG_W-1:0]  ncfg_q,
    output logic [CFG_W-1:0]  dcfg_q
);
    localparam int GW = NG + DG;

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // Control register: warm-response enables, default on.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_rst)            warm_en <= '1;
        else if (wr_en && addr == A_CTRL)  warm_en <= wdata[N_DOM-1:0];
    end

    // Gate-enable register for software-managed clocks, default off.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_rst)            gate_q <= '0;
        else if (wr_en && addr == A_GATE)  gate_q <= wdata[GW-1:0];
    end

    // Generator configuration words, one per domain.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_rst) begin
            ncfg_q <= '0;
            dcfg_q <= '0;
        end else if (wr_en) begin
            if (addr == A_NCFG) ncfg_q <= wdata[CFG_W-1:0];
            if (addr == A_DCFG) dcfg_q <= wdata[CFG_W-1:0];
        end
    end

    // R7: warm reset leaves the enables untouched
    p_warm_keeps_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst && !cold_rst && !(wr_en && addr == A_CTRL)) |=> $stable(warm_en));

    // R3/R5: a safe request alone never alters stored settings
    p_req_keeps_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_req && !cold_rst && !wr_en) |=> ($stable(ncfg_q) && $stable(dcfg_q) && $stable(gate_q)));
endmodule

// File: rtl/clkmgr_safe_status.sv
// Sticky per-domain safe flags. Set by cold reset, safe request or an enabled
// warm reset; cleared only by a write-1-to-clear to the status address.
// Set takes priority over clear in the same cycle.
module clkmgr_safe_status
    import clkmgr_safe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              safe_req,
    input  logic [N_DOM-1:0]  warm_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_DOM-1:0]  wbits,
    output logic [N_DOM-1:0]  safe_q
);
    logic sts_wr;
    assign sts_wr = wr_en && (addr == A_STS);

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        logic set_d, clr_d;
        assign set_d = cold_rst || safe_req || (warm_rst && warm_en[d]);
        assign clr_d = sts_wr && wbits[d];

        // One sticky flag per domain, set dominant.
        always_ff @(posedge clk) begin
            if (!rst_n)      safe_q[d] <= 1'b1;
            else if (set_d)  safe_q[d] <= 1'b1;
            else if (clr_d)  safe_q[d] <= 1'b0;
        end

        // R4: only a software clear can drop the flag
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (safe_q[d] && !(sts_wr && wbits[d])) |=> safe_q[d]);
        // R6: enabled warm reset sets the flag
        p_warm_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_rst && warm_en[d]) |=> safe_q[d]);
        // R9: a set in the same cycle as a clear wins
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((safe_req || cold_rst) && sts_wr && wbits[d]) |=> safe_q[d]);
    end

    // R2/R3: cold reset and safe request set every domain
    p_req_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_req || cold_rst) |=> (safe_q == '1));
endmodule

// File: rtl/clkmgr_safe_mask.sv
// Output forcing for one domain: while safe, the configuration word is
// replaced by SAFE_CFG, gates are held off and the bypass select is raised.
// Assumes the stored inputs come straight from registers.
module clkmgr_safe_mask #(
    parameter int                 CFG_W    = 8,
    parameter int                 GATES    = 4,
    parameter logic [CFG_W-1:0]   SAFE_CFG = '0
) (
    input  logic             safe,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic [GATES-1:0] gate_in,
    output logic [CFG_W-1:0] cfg_out,
    output logic [GATES-1:0] gate_out,
    output logic             bypass
);
    // Select stored or forced values for this domain.
    always_comb begin
        bypass   = safe;
        cfg_out  = safe ? SAFE_CFG : cfg_in;
        gate_out = safe ? '0 : gate_in;
    end
endmodule

// File: rtl/clkmgr_safe_ctrl.sv
// Top of the safe-mode controller: register file, sticky safe flags, per-domain
// output forcing and a combinational read mux. Synchronous active-low reset
// acts as a cold reset. Reads return current state in the same cycle.
module clkmgr_safe_ctrl
    import clkmgr_safe_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter int               NG       = 4,
    parameter int               DG       = 2,
    parameter int               CFG_W    = 8,
    parameter logic [CFG_W-1:0] SAFE_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              safe_req,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CFG_W-1:0]  norm_cfg_o,
    output logic [CFG_W-1:0]  dbg_cfg_o,
    output logic [NG-1:0]     norm_gate_o,
    output logic [DG-1:0]     dbg_gate_o,
    output logic              norm_bypass_o,
    output logic              dbg_bypass_o
);
    localparam int GW = NG + DG;

    logic [N_DOM-1:0] warm_en;
    logic [N_DOM-1:0] safe_q;
    logic [GW-1:0]    gate_q;
    logic [CFG_W-1:0] ncfg_q, dcfg_q;

    clkmgr_safe_regs #(.DATA_W(DATA_W), .NG(NG), .DG(DG), .CFG_W(CFG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .safe_req(safe_req), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .warm_en(warm_en), .gate_q(gate_q), .ncfg_q(ncfg_q), .dcfg_q(dcfg_q)
    );

    clkmgr_safe_status u_status (
        .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .safe_req(safe_req), .warm_en(warm_en), .wr_en(wr_en), .addr(addr),
        .wbits(wdata[N_DOM-1:0]), .safe_q(safe_q)
    );

    clkmgr_safe_mask #(.CFG_W(CFG_W), .GATES(NG), .SAFE_CFG(SAFE_CFG)) u_mask_norm (
        .safe(safe_q[DOM_NORM]), .cfg_in(ncfg_q), .gate_in(gate_q[NG-1:0]),
        .cfg_out(norm_cfg_o), .gate_out(norm_gate_o), .bypass(norm_bypass_o)
    );

    clkmgr_safe_mask #(.CFG_W(CFG_W), .GATES(DG), .SAFE_CFG(SAFE_CFG)) u_mask_dbg (
        .safe(safe_q[DOM_DBG]), .cfg_in(dcfg_q), .gate_in(gate_q[GW-1:NG]),
        .cfg_out(dbg_cfg_o), .gate_out(dbg_gate_o), .bypass(dbg_bypass_o)
    );

    // Read mux over current register state; zero when idle or unmapped.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL:  rdata[N_DOM-1:0] = warm_en;
                A_STS:   rdata[N_DOM-1:0] = safe_q;
                A_GATE:  rdata[GW-1:0]    = gate_q;
                A_NCFG:  rdata[CFG_W-1:0] = ncfg_q;
                A_DCFG:  rdata[CFG_W-1:0] = dcfg_q;
                default: rdata = '0;
            endcase
        end
    end

    // R2: after a cold reset the enables are back at their default
    p_cold_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst |=> (warm_en == '1 && gate_q == '0));
endmodule

// File: tb/clkmgr_safe_ctrl_bench.sv
`timescale 1ns/1ps
module clkmgr_safe_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n, cold_rst, warm_rst, safe_req, rd_en, wr_en;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  norm_cfg_o, dbg_cfg_o;
    logic [3:0]  norm_gate_o;
    logic [1:0]  dbg_gate_o;
    logic        norm_bypass_o, dbg_bypass_o;

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the register state
    logic [1:0] m_en, m_sts;
    logic [5:0] m_gate;
    logic [7:0] m_ncfg, m_dcfg;

    always #2.5 clk = ~clk;

    clkmgr_safe_ctrl u_clkmgr_safe_ctrl (
        .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .safe_req(safe_req), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .norm_cfg_o(norm_cfg_o), .dbg_cfg_o(dbg_cfg_o),
        .norm_gate_o(norm_gate_o), .dbg_gate_o(dbg_gate_o),
        .norm_bypass_o(norm_bypass_o), .dbg_bypass_o(dbg_bypass_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: exp_read = {30'd0, m_en};
            3'd1: exp_read = {30'd0, m_sts};
            3'd2: exp_read = {26'd0, m_gate};
            3'd3: exp_read = {24'd0, m_ncfg};
            3'd4: exp_read = {24'd0, m_dcfg};
            default: exp_read = 32'd0;
        endcase
    endfunction

    // advance model by one edge with the inputs currently driven
    function automatic void model_step();
        logic [1:0] nsts;
        if (!rst_n || cold_rst) begin
            m_en = 2'b11; m_sts = 2'b11; m_gate = '0; m_ncfg = '0; m_dcfg = '0;
            return;
        end
        for (int d = 0; d < 2; d++) begin
            if (safe_req || (warm_rst && m_en[d]))         nsts[d] = 1'b1;
            else if (wr_en && addr == 3'd1 && wdata[d])    nsts[d] = 1'b0;
            else                                           nsts[d] = m_sts[d];
        end
        m_sts = nsts;
        if (wr_en) begin
            case (addr)
                3'd0: m_en   = wdata[1:0];
                3'd2: m_gate = wdata[5:0];
                3'd3: m_ncfg = wdata[7:0];
                3'd4: m_dcfg = wdata[7:0];
                default: ;
            endcase
        end
    endfunction

    task automatic check_outputs();
        chk("R1 normal bypass", {31'd0, norm_bypass_o}, {31'd0, m_sts[0]});
        chk("R1 debug bypass",  {31'd0, dbg_bypass_o},  {31'd0, m_sts[1]});
        chk("R1/R5 normal cfg", {24'd0, norm_cfg_o}, {24'd0, m_sts[0] ? 8'd0 : m_ncfg});
        chk("R1/R5 debug cfg",  {24'd0, dbg_cfg_o},  {24'd0, m_sts[1] ? 8'd0 : m_dcfg});
        chk("R8 normal gates",  {28'd0, norm_gate_o}, {28'd0, m_sts[0] ? 4'd0 : m_gate[3:0]});
        chk("R8 debug gates",   {30'd0, dbg_gate_o},  {30'd0, m_sts[1] ? 2'd0 : m_gate[5:4]});
    endtask

    // one cycle: drive at falling edge, check read, clock, check outputs
    task automatic cyc(input string tag, input logic rn, input logic cr, input logic wr_rst,
                       input logic sr, input logic rd, input logic wr,
                       input logic [2:0] a, input logic [31:0] wd);
        rst_n = rn; cold_rst = cr; warm_rst = wr_rst; safe_req = sr;
        rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        #1;
        chk({tag, " R10 read"}, rdata, rd ? exp_read(a) : 32'd0);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a);
        cyc(tag, 1, 0, 0, 0, 1, 0, a, 32'd0);
    endtask

    task automatic wr_do(input logic [2:0] a, input logic [31:0] d);
        cyc("write", 1, 0, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; cold_rst = 0; warm_rst = 0; safe_req = 0;
        rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
        m_en = 'x; m_sts = 'x; m_gate = 'x; m_ncfg = 'x; m_dcfg = 'x;
        @(negedge clk);
        cyc("R2 reset", 0, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        // R2/R7 reset state read back
        for (int a = 0; a < 8; a++) rd_chk("R2 R7 reset state", 3'(a));

        // R5: write while safe, stored but masked
        wr_do(3'd2, 32'h3F); wr_do(3'd3, 32'hA5); wr_do(3'd4, 32'h3C);
        rd_chk("R5 gate stored", 3'd2); rd_chk("R5 ncfg stored", 3'd3);

        // R4: writing 0 does not clear; other addresses do not clear
        wr_do(3'd1, 32'h0); wr_do(3'd0, 32'h3); rd_chk("R4 no clear", 3'd1);
        wr_do(3'd1, 32'h1); rd_chk("R4 clear normal", 3'd1);
        wr_do(3'd1, 32'h2); rd_chk("R4 clear debug", 3'd1);

        // R3: request sets both, settings kept
        cyc("R3 request", 1, 0, 0, 1, 0, 0, 3'd0, 32'd0);
        rd_chk("R3 flags", 3'd1); rd_chk("R3 cfg kept", 3'd3); rd_chk("R3 gate kept", 3'd2);

        // R6/R7: warm reset with each enable pattern
        for (int p = 0; p < 4; p++) begin
            wr_do(3'd1, 32'h3);
            wr_do(3'd0, 32'(p));
            cyc("R6 warm", 1, 0, 1, 0, 0, 0, 3'd0, 32'd0);
            rd_chk("R6 warm flags", 3'd1);
            rd_chk("R7 enables kept", 3'd0);
        end

        // R9: set and clear in the same cycle
        wr_do(3'd1, 32'h3);
        cyc("R9 req vs clear", 1, 0, 0, 1, 0, 1, 3'd1, 32'h3);
        rd_chk("R9 flags", 3'd1);
        wr_do(3'd0, 32'h1); wr_do(3'd1, 32'h3);
        cyc("R9 warm vs clear", 1, 0, 1, 0, 0, 1, 3'd1, 32'h3);
        rd_chk("R9 warm flags", 3'd1);

        // R2: cold reset input restores defaults
        wr_do(3'd1, 32'h3); wr_do(3'd0, 32'h0);
        cyc("R2 cold", 1, 1, 0, 0, 0, 0, 3'd0, 32'd0);
        for (int a = 0; a < 5; a++) rd_chk("R2 cold defaults", 3'(a));

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic rn, cr, wrr, sr, rd, wr;
            rn  = ($urandom % 200) != 0;
            cr  = ($urandom % 80) == 0;
            wrr = ($urandom % 30) == 0;
            sr  = ($urandom % 30) == 0;
            rd  = ($urandom % 2) == 0;
            wr  = ($urandom % 3) == 0;
            cyc("random", rn, cr, wrr, sr, rd, wr, 3'($urandom % 8), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule